// File: doc/BRIEF.md
# Second-Level Memory Partition and Requester Control

This block holds the configuration word for a 64 KB second-level memory built from four equal 16 KB segments, and drives the control that follows from it. A three-bit mode field sets how many segments serve as cache ways. The rest stay directly addressed RAM. RAM always takes the lowest segments and cache ways the highest. The block reports the enabled way count and classifies each incoming byte address as a RAM hit or as an illegal direct access into a cache segment.

Two write-only bits of the word request a flush of every line in the first-level data cache or the first-level program cache. Each request leaves the block as a single-cycle pulse. When a mode write enlarges the cache, a per-segment pulse marks the segments that have just become ways, so their tags can be cleared.

A priority bit chooses whether CPU or DMA requests win at the second level. The block contains the two-requester arbiter that applies this bit and keeps a grant until its owner lets go.

Top module: `l2p_ctrl`

## Requirements
- R1: While and after synchronous reset (`rst` high at a rising edge), `cfg_rdata` is 0, `ways_en` is 0, both grants are low and every pulse output is low.
- R2: A write places `cfg_wdata[2:0]` in the mode field. The enabled way count on `ways_en` is 0 for code 000, 1 for 001, 2 for 010, 3 for 011 and 4 for 111.
- R3: A write carrying mode code 100, 101 or 110 leaves the mode field and `ways_en` unchanged. The other fields of that write still take effect.
- R4: `cfg_rdata` returns the priority bit in bit 31 and the mode in bits 2:0. Every other bit reads 0, including the write-only bits 8 and 9. A write updates the priority bit from `cfg_wdata[31]`.
- R5: A write with `cfg_wdata[8]` = 1 raises `inv_l1d` for exactly the one cycle after the write edge. A write with `cfg_wdata[9]` = 1 does the same on `inv_l1p`. Writing 0 to these bits gives no pulse.
- R6: Segment index is `acc_addr[15:14]`. With W enabled ways, segments below 4-W are RAM. When `acc_valid` is high, `ram_hit` is 1 for an address in a RAM segment and `seg_err` is 1 for an address in a cache segment. Both are 0 when `acc_valid` is low.
- R7: A legal mode write that raises the way count from A to B sets `inv_l2_seg[s]` for one cycle for each segment s with 4-B <= s < 4-A. A write that keeps or lowers the count pulses no bit.
- R8: When no grant is held and both request, the CPU is granted if the priority bit is 0 and the DMA is granted if it is 1. A lone requester is granted. Grants appear one cycle after the request is sampled.
- R9: A granted requester keeps its grant every cycle it keeps requesting, whatever the other request and the priority bit do.
- R10: At most one grant is high in any cycle. A grant is high only if its requester was requesting at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| acc_valid | input | 1 | Direct RAM access present |
| acc_addr | input | 16 | Byte address of the direct access |
| ram_hit | output | 1 | Access falls in mapped RAM |
| seg_err | output | 1 | Access falls in a cache segment |
| ways_en | output | 3 | Number of enabled cache ways |
| inv_l1d | output | 1 | Flush pulse to first-level data cache |
| inv_l1p | output | 1 | Flush pulse to first-level program cache |
| inv_l2_seg | output | 4 | Per-segment tag-clear pulse for new ways |
| cpu_req | input | 1 | CPU request |
| dma_req | input | 1 | DMA request |
| cpu_gnt | output | 1 | CPU grant |
| dma_gnt | output | 1 | DMA grant |

## Verification
Every registered result is due in the cycle right after the edge that samples its cause. This covers the read-back word, the way count, the three pulse outputs and the grants. The address classification is combinational on the current mode and address, so it is due in the same cycle. The bench changes inputs just after a falling edge and compares all outputs at the next falling edge against a behavioural model. The model advances on the same rising edge as the design, so a pulse that is one cycle late or lasts two cycles shows up as a mismatch.

// File: rtl/l2p_pkg.sv
package l2p_pkg;

    localparam int SEGS       = 4;
    localparam int SEG_W      = $clog2(SEGS);
    localparam int WAYS_W     = $clog2(SEGS + 1);
    localparam int CFG_W      = 32;
    localparam int MODE_W     = 3;
    localparam int BIT_INV_D  = 8;
    localparam int BIT_INV_P  = 9;
    localparam int BIT_PRIO   = 31;

    typedef enum logic [MODE_W-1:0] {
        MODE_SRAM = 3'b000,
        MODE_1WAY = 3'b001,
        MODE_2WAY = 3'b010,
        MODE_3WAY = 3'b011,
        MODE_4WAY = 3'b111
    } l2_mode_e;

    typedef struct packed {
        logic     prio_dma;
        l2_mode_e mode;
    } cfg_state_t;

    typedef struct packed {
        logic            inv_d;
        logic            inv_p;
        logic [SEGS-1:0] inv_seg;
    } inv_pulse_t;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2
    } owner_e;

    function automatic logic mode_legal(input logic [MODE_W-1:0] code);
        case (code)
            3'b000, 3'b001, 3'b010, 3'b011, 3'b111: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic [WAYS_W-1:0] mode_ways(input l2_mode_e m);
        case (m)
            MODE_1WAY: return WAYS_W'(1);
            MODE_2WAY: return WAYS_W'(2);
            MODE_3WAY: return WAYS_W'(3);
            MODE_4WAY: return WAYS_W'(4);
            default:   return WAYS_W'(0);
        endcase
    endfunction

    // Segments at or above SEGS-ways are cache ways.
    function automatic logic [SEGS-1:0] cache_mask(input logic [WAYS_W-1:0] ways);
        logic [SEGS-1:0] m;
        for (int s = 0; s < SEGS; s++) begin
            m[s] = (s >= (SEGS - int'(ways)));
        end
        return m;
    endfunction

endpackage

// File: rtl/l2p_cfg_reg.sv
module l2p_cfg_reg
    import l2p_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [CFG_W-1:0]    wdata,
    output cfg_state_t          cfg_q,
    output inv_pulse_t          pulse_q,
    output logic [CFG_W-1:0]    rdata,
    output logic [WAYS_W-1:0]   ways
);

    logic                 code_ok;
    l2_mode_e             next_mode;
    logic [SEGS-1:0]      old_mask;
    logic [SEGS-1:0]      new_mask;

    assign code_ok   = mode_legal(wdata[MODE_W-1:0]);
    assign next_mode = code_ok ? l2_mode_e'(wdata[MODE_W-1:0]) : cfg_q.mode;
    assign ways      = mode_ways(cfg_q.mode);
    assign old_mask  = cache_mask(ways);
    assign new_mask  = cache_mask(mode_ways(next_mode));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.prio_dma <= 1'b0;
            cfg_q.mode     <= MODE_SRAM;
            pulse_q        <= '0;
        end else begin
            pulse_q.inv_d   <= wr_en & wdata[BIT_INV_D];
            pulse_q.inv_p   <= wr_en & wdata[BIT_INV_P];
            pulse_q.inv_seg <= wr_en ? (new_mask & ~old_mask) : '0;
            if (wr_en) begin
                cfg_q.prio_dma <= wdata[BIT_PRIO];
                cfg_q.mode     <= next_mode;
            end
        end
    end

    always_comb begin
        rdata                 = '0;
        rdata[BIT_PRIO]       = cfg_q.prio_dma;
        rdata[MODE_W-1:0]     = cfg_q.mode;
    end

    // R3: an illegal code never moves the mode
    a_r3_reserved_kept: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && !$past(code_ok)) |-> $stable(cfg_q.mode));

    // R5: a flush pulse only follows a write that set its bit
    a_r5_inv_d_cause: assert property (@(posedge clk) disable iff (rst)
        pulse_q.inv_d |-> ($past(wr_en) && $past(wdata[BIT_INV_D])));
    a_r5_inv_p_cause: assert property (@(posedge clk) disable iff (rst)
        pulse_q.inv_p |-> ($past(wr_en) && $past(wdata[BIT_INV_P])));

    // R7: new-way pulses only after a write, and only for segments now cached
    a_r7_seg_after_write: assert property (@(posedge clk) disable iff (rst)
        (pulse_q.inv_seg != '0) |-> $past(wr_en));
    a_r7_seg_now_cache: assert property (@(posedge clk) disable iff (rst)
        (pulse_q.inv_seg & ~old_mask) == '0);

endmodule

// File: rtl/l2p_addr_dec.sv
module l2p_addr_dec
    import l2p_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [WAYS_W-1:0]   ways,
    output logic                ram_hit,
    output logic                seg_err
);

    localparam int SEG_LSB = ADDR_W - SEG_W;

    logic [SEG_W-1:0] seg;
    logic [SEGS-1:0]  way_mask;
    logic             in_cache;

    assign seg      = acc_addr[ADDR_W-1:SEG_LSB];
    assign way_mask = cache_mask(ways);
    assign in_cache = way_mask[seg];
    assign ram_hit  = acc_valid & ~in_cache;
    assign seg_err  = acc_valid &  in_cache;

    // R6: the two outcomes are exclusive and need a valid access
    always_comb begin
        a_r6_exclusive: assert (!(ram_hit && seg_err));
        a_r6_needs_valid: assert (acc_valid || !(ram_hit || seg_err));
    end

endmodule

// File: rtl/l2p_arb.sv
module l2p_arb
    import l2p_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic prio_dma,
    input  logic cpu_req,
    input  logic dma_req,
    output logic cpu_gnt,
    output logic dma_gnt
);

    owner_e owner_q;
    owner_e owner_d;

    always_comb begin
        owner_d = OWN_NONE;
        if (owner_q == OWN_CPU && cpu_req) begin
            owner_d = OWN_CPU;
        end else if (owner_q == OWN_DMA && dma_req) begin
            owner_d = OWN_DMA;
        end else if (cpu_req && dma_req) begin
            owner_d = prio_dma ? OWN_DMA : OWN_CPU;
        end else if (cpu_req) begin
            owner_d = OWN_CPU;
        end else if (dma_req) begin
            owner_d = OWN_DMA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_NONE;
        else     owner_q <= owner_d;
    end

    assign cpu_gnt = (owner_q == OWN_CPU);
    assign dma_gnt = (owner_q == OWN_DMA);

    // R10: one grant at most, each backed by a request
    a_r10_one_grant: assert property (@(posedge clk) disable iff (rst)
        !(cpu_gnt && dma_gnt));
    a_r10_cpu_backed: assert property (@(posedge clk) disable iff (rst)
        cpu_gnt |-> $past(cpu_req));
    a_r10_dma_backed: assert property (@(posedge clk) disable iff (rst)
        dma_gnt |-> $past(dma_req));

    // R9: holder keeps its grant while it requests
    a_r9_hold_cpu: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt && cpu_req) |=> cpu_gnt);
    a_r9_hold_dma: assert property (@(posedge clk) disable iff (rst)
        (dma_gnt && dma_req) |=> dma_gnt);

endmodule

// File: rtl/l2p_ctrl.sv
module l2p_ctrl
    import l2p_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic                ram_hit,
    output logic                seg_err,
    output logic [2:0]          ways_en,
    output logic                inv_l1d,
    output logic                inv_l1p,
    output logic [3:0]          inv_l2_seg,
    input  logic                cpu_req,
    input  logic                dma_req,
    output logic                cpu_gnt,
    output logic                dma_gnt
);

    cfg_state_t          cfg_q;
    inv_pulse_t          pulse_q;
    logic [WAYS_W-1:0]   ways;

    l2p_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q),
        .pulse_q (pulse_q),
        .rdata   (cfg_rdata),
        .ways    (ways)
    );

    l2p_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .ways      (ways),
        .ram_hit   (ram_hit),
        .seg_err   (seg_err)
    );

    l2p_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .prio_dma (cfg_q.prio_dma),
        .cpu_req  (cpu_req),
        .dma_req  (dma_req),
        .cpu_gnt  (cpu_gnt),
        .dma_gnt  (dma_gnt)
    );

    assign ways_en    = ways;
    assign inv_l1d    = pulse_q.inv_d;
    assign inv_l1p    = pulse_q.inv_p;
    assign inv_l2_seg = pulse_q.inv_seg;

    // R2: way count never exceeds the segment count
    a_r2_ways_range: assert property (@(posedge clk) disable iff (rst)
        ways_en <= 3'd4);

endmodule

// File: tb/sim_l2p_ctrl.sv
module sim_l2p_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        ram_hit, seg_err;
    logic [2:0]  ways_en;
    logic        inv_l1d, inv_l1p;
    logic [3:0]  inv_l2_seg;
    logic        cpu_req = 1'b0, dma_req = 1'b0;
    logic        cpu_gnt, dma_gnt;

    always #10 clk = ~clk;   // 50 MHz

    l2p_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .ram_hit(ram_hit), .seg_err(seg_err), .ways_en(ways_en),
        .inv_l1d(inv_l1d), .inv_l1p(inv_l1p), .inv_l2_seg(inv_l2_seg),
        .cpu_req(cpu_req), .dma_req(dma_req), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit running = 0;

    // behavioural reference state
    int m_mode = 0;
    int m_prio = 0;
    int m_l1d = 0, m_l1p = 0, m_l2 = 0;
    int m_owner = 0;   // 0 none, 1 cpu, 2 dma

    function automatic int ways_of(input int code);
        case (code)
            1: return 1;
            2: return 2;
            3: return 3;
            7: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit legal(input int code);
        return (code <= 3) || (code == 7);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_prio = 0; m_l1d = 0; m_l1p = 0; m_l2 = 0; m_owner = 0;
        end else begin
            int ow, nw, code;
            // arbiter uses the priority held before this edge
            if (m_owner == 1 && cpu_req)       m_owner = 1;
            else if (m_owner == 2 && dma_req)  m_owner = 2;
            else if (cpu_req && dma_req)       m_owner = (m_prio != 0) ? 2 : 1;
            else if (cpu_req)                  m_owner = 1;
            else if (dma_req)                  m_owner = 2;
            else                               m_owner = 0;
            m_l1d = cfg_wr && cfg_wdata[8];
            m_l1p = cfg_wr && cfg_wdata[9];
            m_l2  = 0;
            if (cfg_wr) begin
                code = int'(cfg_wdata[2:0]);
                ow = ways_of(m_mode);
                if (legal(code)) begin
                    nw = ways_of(code);
                    for (int s = 0; s < 4; s++)
                        if (s >= 4 - nw && s < 4 - ow) m_l2 |= (1 << s);
                    m_mode = code;
                end
                m_prio = cfg_wdata[31];
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            int seg, w;
            seg = int'(acc_addr[15:14]);
            w   = ways_of(m_mode);
            chk("R4 R3 rdata", cfg_rdata, (m_prio << 31) | m_mode);
            chk("R2 R3 ways_en", ways_en, w);
            chk("R5 inv_l1d", inv_l1d, m_l1d);
            chk("R5 inv_l1p", inv_l1p, m_l1p);
            chk("R7 inv_l2_seg", inv_l2_seg, m_l2);
            chk("R6 ram_hit", ram_hit, acc_valid && (seg < 4 - w));
            chk("R6 seg_err", seg_err, acc_valid && (seg >= 4 - w));
            chk("R8 R9 R10 cpu_gnt", cpu_gnt, m_owner == 1);
            chk("R8 R9 R10 dma_gnt", dma_gnt, m_owner == 2);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0;
        step(1);
    endtask

    task automatic sweep();
        for (int a = 0; a < 8; a++) begin
            acc_valid = (a != 5);
            acc_addr  = 16'(a * 8192 + 16'h0123);
            step(1);
        end
        acc_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        step(3);
        // R1: reset state
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 ways", ways_en, 0);
        chk("R1 pulses", {inv_l1d, inv_l1p, inv_l2_seg}, 0);
        chk("R1 grants", {cpu_gnt, dma_gnt}, 0);
        rst = 1'b0;
        running = 1;
        step(1);
        sweep();
        wr(32'h0000_0001); sweep();          // R2 R7 one way
        wr(32'h0000_0002); sweep();          // R7 second way
        wr(32'h0000_0005); sweep();          // R3 reserved kept
        wr(32'h0000_0007); sweep();          // R7 two more ways
        wr(32'h0000_0003);                   // R7 shrink, no pulse
        wr(32'h0000_0000); sweep();
        wr(32'hFFFF_FB04);                   // R3 R4 R5 reserved mode, other bits
        wr(32'h0000_0300);                   // R5 both flushes
        wr(32'h0000_0100);
        wr(32'h0000_0200);
        wr(32'h0000_0006);                   // R3
        wr(32'h8000_0007);                   // R4 priority to DMA
        // R8 both from idle, DMA wins
        cpu_req = 1; dma_req = 1; step(4);
        // R9 priority flips while DMA holds
        wr(32'h0000_0007); step(2);
        dma_req = 0; step(3);                // CPU takes over
        dma_req = 1; step(3);                // CPU still holds
        cpu_req = 0; dma_req = 0; step(2);
        cpu_req = 1; dma_req = 1; step(3);   // R8 CPU wins with priority 0
        cpu_req = 0; dma_req = 0; step(2);
        for (int i = 0; i < 600; i++) begin
            int pick;
            pick = int'($urandom % 8);
            cpu_req   = $urandom % 3 != 0;
            dma_req   = $urandom % 3 != 0;
            acc_valid = $urandom % 2;
            acc_addr  = 16'($urandom);
            cfg_wr    = ($urandom % 5 == 0);
            cfg_wdata = $urandom;
            cfg_wdata[2:0] = 3'(pick);
            step(1);
        end
        cfg_wr = 0; cpu_req = 0; dma_req = 0; acc_valid = 0;
        step(3);
        summary();
    end

endmodule